// File: doc/BRIEF.md
# Frame Stream DMA Buffer with Zero Fill

This block sits between an image sensor that delivers one reformatted pixel word every few clock cycles and a system bus that moves data to memory in granted bursts. The sensor cannot be paused, so words go into a very small ring buffer. When the buffer holds enough words, the block asks the bus for a grant. Each grant empties the buffer into memory, one word per cycle, at an address that starts at a loaded base and steps by one word per beat.

If grants come too slowly and the buffer is full when a word arrives, that word is lost. The block counts the loss and later writes a zero word in its place. The frame in memory therefore keeps its exact word count and every pixel stays at its expected offset. At ten cycles per word and twelve entries, a request must be served within about 120 cycles to avoid any loss.

The host sets the base address, the frame length in words and the request threshold, then pulses a start input. The block raises `done` once the whole frame has been written.

Top module: `frame_dma_buffer`

## Requirements
- R1: After reset, `dma_req`, `dma_beat`, `busy` and `done` are low and `drop_count` is zero.
- R2: A one-cycle `start` pulse captures `cfg_base`, `cfg_words` and `cfg_thresh`. It empties the buffer, clears `drop_count` and `done`, and raises `busy`.
- R3: `dma_req` rises only when the buffer level is at least the effective threshold, or when every word of the frame has arrived and words remain buffered. A threshold of 0 acts as 1, and a threshold above DEPTH acts as DEPTH. A `dma_gnt` given while `dma_req` is low is ignored.
- R4: A grant taken while `dma_req` is high starts a burst on the next cycle. The burst moves exactly the number of words buffered at the grant, with `dma_beat` high on consecutive cycles and `dma_req` low throughout.
- R5: Beat k of a frame (k counted from 0 over the whole frame) carries address `cfg_base + k*(DATA_W/8)`.
- R6: Words reach memory in arrival order.
- R7: A word arriving while the buffer is full is dropped. It adds one to `drop_count`, and a zero word takes its place in the stream once space frees up.
- R8: A word arriving while earlier zero words are still owed but the buffer has space is also replaced by a zero word and counted as dropped, so order is kept.
- R9: `drop_count` is DROP_W bits wide and saturates at its all-ones value.
- R10: Once `cfg_words` beats have been written, `done` rises and `busy` falls. Further pixel strobes and grants then have no effect until the next start.
- R11: With a threshold of 1 and every request granted within a few arrival intervals, no word is dropped and memory receives the exact pixel sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a frame and captures the configuration |
| cfg_base | input | ADDR_W | First memory byte address of the frame |
| cfg_words | input | CNT_W | Frame length in words |
| cfg_thresh | input | $clog2(DEPTH+1) | Buffered-word threshold for requesting the bus |
| pix_stb | input | 1 | One-cycle strobe marking a new pixel word |
| pix_data | input | DATA_W | Pixel word |
| dma_req | output | 1 | Bus request |
| dma_gnt | input | 1 | Bus grant |
| dma_beat | output | 1 | A word is written this cycle |
| dma_addr | output | ADDR_W | Byte address of the current beat |
| dma_data | output | DATA_W | Word of the current beat |
| drop_count | output | DROP_W | Saturating count of lost words |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame fully written |

## Verification
The bench keeps the twelve-entry buffer and 32-bit words, but builds the block with DROP_W = 4. That makes the lost-word counter saturate at 15 within a 40-word frame in which grants are withheld. CNT_W = 16 keeps the frames short. With bus grants held off under script control, the exact words that fill the buffer, the words replaced by zeros, and the arrival that lands while zeros are still owed can all be predicted and compared at every address.

// File: rtl/fdb_pkg.sv
// Shared types for the frame stream DMA buffer.
package fdb_pkg;
    // Burst engine state: waiting for a grant, or streaming beats.
    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_BURST = 1'b1
    } eng_state_e;
endpackage

// File: rtl/fdb_ring.sv
// Ring buffer of DEPTH words with a level counter.
// Assumes the caller never pushes when full and never pops when empty.
// A clear empties it; stored contents are not reset.
module fdb_ring #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 12,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [LVL_W-1:0]  level,
    output logic              full
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: ;
            endcase
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    assign head = mem[rd_ptr];
    assign full = (level == LVL_W'(DEPTH));

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |-> !full); // R7
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear) |-> (level != '0)); // R4
endmodule

// File: rtl/fdb_ingest.sv
// Input side: accepts pixel strobes up to the frame length. It replaces
// lost words with zero words and counts the losses in a saturating counter.
// Assumes at most one strobe per cycle; a zero owed is written in any
// cycle with space and no arrival.
module fdb_ingest #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 20,
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              active,
    input  logic [CNT_W-1:0]  total,
    input  logic              pix_stb,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              full,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic [DROP_W-1:0] drop_cnt,
    output logic              all_in
);
    logic [CNT_W-1:0] in_cnt;
    logic [CNT_W-1:0] owed;
    logic             take;
    logic             lost;

    assign take = active && pix_stb && (in_cnt != total);
    assign lost = take && (full || (owed != '0));

    // Choose what enters the buffer this cycle.
    always_comb begin
        push      = 1'b0;
        push_data = '0;
        if (take) begin
            if (!full) begin
                push      = 1'b1;
                push_data = (owed == '0) ? pix_data : '0;
            end
        end else if ((owed != '0) && !full) begin
            push = 1'b1;
        end
    end

    // Arrival count, owed zero words and saturating loss count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            in_cnt   <= '0;
            owed     <= '0;
            drop_cnt <= '0;
        end else begin
            if (take) in_cnt <= in_cnt + 1'b1;
            if (take && full)
                owed <= owed + 1'b1;
            else if (!take && (owed != '0) && !full)
                owed <= owed - 1'b1;
            if (lost && (drop_cnt != '1)) drop_cnt <= drop_cnt + 1'b1;
        end
    end

    assign all_in = (in_cnt == total) && (owed == '0);

    AST_DROP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (drop_cnt >= $past(drop_cnt))); // R9
endmodule

// File: rtl/fdb_dma_eng.sv
// Burst engine: requests the bus when enough words are buffered, or when
// the frame tail has fully arrived. On a grant it streams exactly the
// buffered count, one beat per cycle, at an address stepping by one word.
// Assumes thresh has already been clamped to 1..DEPTH.
module fdb_dma_eng
    import fdb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 20,
    parameter int DEPTH  = 12,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int STEP  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [ADDR_W-1:0] base,
    input  logic              active,
    input  logic [CNT_W-1:0]  total,
    input  logic [LVL_W-1:0]  thresh,
    input  logic [LVL_W-1:0]  level,
    input  logic              all_in,
    input  logic [DATA_W-1:0] head,
    input  logic              gnt,
    output logic              req,
    output logic              beat,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              pop,
    output logic              finished
);
    eng_state_e       state;
    logic [LVL_W-1:0] left;
    logic [CNT_W-1:0] wr_cnt;

    assign finished = (wr_cnt == total);
    assign req  = active && (state == ENG_IDLE) && !finished && (level != '0)
                  && ((level >= thresh) || all_in);
    assign beat = (state == ENG_BURST);
    assign pop  = beat;
    assign data = head;

    // Grant capture, beat sequencing, address and written-word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENG_IDLE;
            left   <= '0;
            wr_cnt <= '0;
            addr   <= '0;
        end else if (clear) begin
            state  <= ENG_IDLE;
            left   <= '0;
            wr_cnt <= '0;
            addr   <= base;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (req && gnt) begin
                        state <= ENG_BURST;
                        left  <= level;
                    end
                end
                ENG_BURST: begin
                    addr   <= addr + ADDR_W'(STEP);
                    wr_cnt <= wr_cnt + 1'b1;
                    left   <= left - 1'b1;
                    if (left == LVL_W'(1)) state <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/frame_dma_buffer.sv
// Top level: frame control around the ingest stage, the ring buffer and
// the burst engine. Assumes start is a single-cycle pulse; a start during
// a frame abandons it.
module frame_dma_buffer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 12,
    parameter int CNT_W  = 20,
    parameter int DROP_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_words,
    input  logic [LVL_W-1:0]  cfg_thresh,
    input  logic              pix_stb,
    input  logic [DATA_W-1:0] pix_data,
    output logic              dma_req,
    input  logic              dma_gnt,
    output logic              dma_beat,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [DATA_W-1:0] dma_data,
    output logic [DROP_W-1:0] drop_count,
    output logic              busy,
    output logic              done
);
    logic              active;
    logic [CNT_W-1:0]  total_r;
    logic [LVL_W-1:0]  thr_r;
    logic              push;
    logic [DATA_W-1:0] push_data;
    logic              pop;
    logic [DATA_W-1:0] head;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_full;
    logic              all_in;
    logic              finished;

    function automatic logic [LVL_W-1:0] clamp_thr(input logic [LVL_W-1:0] t);
        if (t == '0) return LVL_W'(1);
        if (t > LVL_W'(DEPTH)) return LVL_W'(DEPTH);
        return t;
    endfunction

    // Frame control: capture configuration, then finish after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            done    <= 1'b0;
            total_r <= '0;
            thr_r   <= LVL_W'(1);
        end else if (start) begin
            active  <= 1'b1;
            done    <= 1'b0;
            total_r <= cfg_words;
            thr_r   <= clamp_thr(cfg_thresh);
        end else if (active && finished) begin
            active <= 1'b0;
            done   <= 1'b1;
        end
    end

    assign busy = active;

    fdb_ingest #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DROP_W(DROP_W)) u_ingest (
        .clk(clk), .rst_n(rst_n), .clear(start), .active(active),
        .total(total_r), .pix_stb(pix_stb), .pix_data(pix_data),
        .full(fifo_full), .push(push), .push_data(push_data),
        .drop_cnt(drop_count), .all_in(all_in)
    );

    fdb_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .clear(start), .push(push),
        .push_data(push_data), .pop(pop), .head(head),
        .level(fifo_level), .full(fifo_full)
    );

    fdb_dma_eng #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_eng (
        .clk(clk), .rst_n(rst_n), .clear(start), .base(cfg_base),
        .active(active), .total(total_r), .thresh(thr_r),
        .level(fifo_level), .all_in(all_in), .head(head), .gnt(dma_gnt),
        .req(dma_req), .beat(dma_beat), .addr(dma_addr), .data(dma_data),
        .pop(pop), .finished(finished)
    );

    AST_BEAT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        dma_beat |-> (fifo_level != '0)); // R4
    AST_GRANT_STARTS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_gnt && !start) |=> dma_beat); // R4
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!dma_req && !dma_beat)); // R10
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R10
endmodule

// File: tb/frame_dma_buffer_test.sv
`timescale 1ns/1ps
module frame_dma_buffer_test;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int DEPTH  = 12;
    localparam int CNT_W  = 16;
    localparam int DROP_W = 4;
    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int MAXW   = 256;
    localparam int DROP_MAX = (1 << DROP_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [CNT_W-1:0]  cfg_words = '0;
    logic [LVL_W-1:0]  cfg_thresh = '0;
    logic              pix_stb = 1'b0;
    logic [DATA_W-1:0] pix_data = '0;
    logic              dma_req;
    logic              dma_gnt;
    logic              dma_beat;
    logic [ADDR_W-1:0] dma_addr;
    logic [DATA_W-1:0] dma_data;
    logic [DROP_W-1:0] drop_count;
    logic              busy;
    logic              done;

    logic gnt_agent = 1'b0;
    logic gnt_force = 1'b0;
    logic gnt_en    = 1'b0;
    int   gnt_delay = 0;
    int   wait_cnt  = 0;
    assign dma_gnt = gnt_agent | gnt_force;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int frame_id = 0;
    int sent   = 0;
    int out_n  = 0;
    logic [DATA_W-1:0] out_data [MAXW];
    logic [ADDR_W-1:0] out_addr [MAXW];
    int                out_cyc  [MAXW];

    frame_dma_buffer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH),
                       .CNT_W(CNT_W), .DROP_W(DROP_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
        .cfg_words(cfg_words), .cfg_thresh(cfg_thresh), .pix_stb(pix_stb),
        .pix_data(pix_data), .dma_req(dma_req), .dma_gnt(dma_gnt),
        .dma_beat(dma_beat), .dma_addr(dma_addr), .dma_data(dma_data),
        .drop_count(drop_count), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Bus grant agent: grants gnt_delay cycles after seeing a request.
    always @(negedge clk) begin
        if (!gnt_en || !dma_req) begin
            gnt_agent <= 1'b0;
            wait_cnt  <= 0;
        end else if (wait_cnt >= gnt_delay) begin
            gnt_agent <= 1'b1;
            wait_cnt  <= 0;
        end else begin
            gnt_agent <= 1'b0;
            wait_cnt  <= wait_cnt + 1;
        end
    end

    // Beat monitor.
    always @(negedge clk) begin
        if (dma_beat && out_n < MAXW) begin
            out_data[out_n] = dma_data;
            out_addr[out_n] = dma_addr;
            out_cyc[out_n]  = cyc;
            out_n = out_n + 1;
        end
    end

    function automatic logic [DATA_W-1:0] exp_word(input int f, input int i);
        return 32'h8000_0000 | (32'(f) << 16) | 32'(i & 16'hFFFF);
    endfunction

    task automatic chk(input logic ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic start_frame(input logic [ADDR_W-1:0] base, input int total, input int thr);
        @(negedge clk);
        out_n = 0;
        frame_id++;
        sent = 0;
        cfg_base = base;
        cfg_words = CNT_W'(total);
        cfg_thresh = LVL_W'(thr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_words(input int n, input int spacing);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_stb = 1'b1;
            pix_data = exp_word(frame_id, sent);
            sent++;
            @(negedge clk);
            pix_stb = 1'b0;
            repeat (spacing - 2) @(negedge clk);
        end
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        @(negedge clk);
        chk(done && !busy, "R10 done/busy after frame", {done, busy}, 2'b10);
    endtask

    // Exact check: positions in [zlo, zhi) expected zero, the rest data.
    task automatic check_exact(input logic [ADDR_W-1:0] base, input int total,
                               input int zlo, input int zhi, input string req);
        logic ok;
        chk(out_n == total, "R10 beat count", out_n, total);
        ok = 1'b1;
        for (int k = 0; k < out_n && k < total; k++) begin
            logic [DATA_W-1:0] e;
            e = (k >= zlo && k < zhi) ? '0 : exp_word(frame_id, k);
            if (out_data[k] !== e) begin
                ok = 1'b0;
                $display("FAIL %s word %0d actual=%0h expected=%0h", req, k, out_data[k], e);
            end
            if (out_addr[k] !== base + ADDR_W'(4 * k)) begin
                ok = 1'b0;
                $display("FAIL R5 addr %0d actual=%0h expected=%0h", k, out_addr[k], base + ADDR_W'(4 * k));
            end
        end
        checks++;
        if (!ok) fails++;
    endtask

    // Loose check for random frames: each word is its pixel or zero (R6, R7).
    task automatic check_loose(input logic [ADDR_W-1:0] base, input int total);
        int zeros;
        logic ok;
        zeros = 0;
        ok = 1'b1;
        chk(out_n == total, "R10 random beat count", out_n, total);
        for (int k = 0; k < out_n && k < total; k++) begin
            if (out_data[k] == '0) zeros++;
            else if (out_data[k] !== exp_word(frame_id, k)) begin
                ok = 1'b0;
                $display("FAIL R6 word %0d actual=%0h expected=%0h", k, out_data[k], exp_word(frame_id, k));
            end
            if (out_addr[k] !== base + ADDR_W'(4 * k)) begin
                ok = 1'b0;
                $display("FAIL R5 addr %0d actual=%0h expected=%0h", k, out_addr[k], base + ADDR_W'(4 * k));
            end
        end
        checks++;
        if (!ok) fails++;
        if (int'(drop_count) < DROP_MAX)
            chk(zeros == int'(drop_count), "R7 zero words equal drops", zeros, drop_count);
        else
            chk(zeros >= DROP_MAX, "R9 zero words at saturation", zeros, DROP_MAX);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!dma_req && !dma_beat && !busy && !done && drop_count == '0,
            "R1 reset outputs", {dma_req, dma_beat, busy, done, drop_count}, 0);

        // Frame A: threshold, ignored grant, burst size, tail flush.
        gnt_en = 1'b0;
        start_frame(32'h0000_1000, 9, 5);
        chk(busy && !done && drop_count == '0, "R2 start state", {busy, done}, 2'b10);
        send_words(2, 10);
        gnt_force = 1'b1;
        @(negedge clk);
        gnt_force = 1'b0;
        @(negedge clk);
        chk(out_n == 0 && !dma_beat, "R3 grant without request ignored", out_n, 0);
        send_words(2, 10);
        chk(!dma_req, "R3 no request below threshold", dma_req, 0);
        send_words(1, 10);
        chk(dma_req, "R3 request at threshold", dma_req, 1);
        gnt_delay = 0;
        gnt_en = 1'b1;
        repeat (10) @(negedge clk);
        chk(out_n == 5, "R4 burst moves buffered count", out_n, 5);
        chk(out_cyc[4] - out_cyc[0] == 4, "R4 consecutive beats", out_cyc[4] - out_cyc[0], 4);
        send_words(4, 10);
        wait_done();
        check_exact(32'h0000_1000, 9, 0, 0, "R6 frame A order");
        chk(out_cyc[5] - out_cyc[4] > 1, "R4 burst ends at grant count", out_cyc[5] - out_cyc[4], 2);

        // Frame B: overrun while full, then arrival while zeros are owed.
        gnt_en = 1'b0;
        start_frame(32'h0002_0000, 30, 1);
        send_words(24, 10);
        chk(drop_count == 4'd12, "R7 drops while full", drop_count, 12);
        gnt_delay = 0;
        gnt_en = 1'b1;
        repeat (3) @(negedge clk);
        send_words(1, 20);
        chk(drop_count == 4'd13, "R8 arrival while zeros owed", drop_count, 13);
        send_words(5, 20);
        wait_done();
        check_exact(32'h0002_0000, 30, 12, 25, "R8 zero fill placement");

        // Frame C: saturation and threshold clamp from above.
        gnt_en = 1'b0;
        start_frame(32'h0003_0000, 40, 15);
        send_words(11, 10);
        chk(!dma_req, "R3 clamp to depth, 11 words", dma_req, 0);
        send_words(1, 10);
        chk(dma_req, "R3 clamp to depth, 12 words", dma_req, 1);
        send_words(28, 10);
        chk(int'(drop_count) == DROP_MAX, "R9 saturated drop count", drop_count, DROP_MAX);
        gnt_en = 1'b1;
        wait_done();
        check_exact(32'h0003_0000, 40, 12, 40, "R7 zeros after overrun");

        // Frame D: prompt grants are lossless; threshold 0 acts as 1.
        gnt_en = 1'b1;
        gnt_delay = 60;
        start_frame(32'h0004_0100, 50, 0);
        send_words(1, 10);
        chk(dma_req, "R3 threshold zero acts as one", dma_req, 1);
        send_words(49, 10);
        wait_done();
        chk(drop_count == '0, "R11 no drops with prompt grants", drop_count, 0);
        check_exact(32'h0004_0100, 50, 0, 0, "R11 exact pixels");

        // Random frames.
        for (int f = 0; f < 4; f++) begin
            int total;
            int thr;
            logic [ADDR_W-1:0] base;
            total = 20 + int'($urandom_range(40));
            thr = int'($urandom_range(15));
            base = {$urandom_range(255), 12'h000} & 32'h000F_F000;
            gnt_delay = int'($urandom_range(200));
            gnt_en = 1'b1;
            start_frame(base, total, thr);
            send_words(total, 10);
            wait_done();
            check_loose(base, total);
        end

        // After done: strobes and grants have no effect.
        begin
            int n0;
            logic [DROP_W-1:0] d0;
            n0 = out_n;
            d0 = drop_count;
            gnt_en = 1'b0;
            send_words(3, 10);
            gnt_force = 1'b1;
            @(negedge clk);
            gnt_force = 1'b0;
            repeat (3) @(negedge clk);
            chk(out_n == n0 && drop_count == d0 && done && !dma_req,
                "R10 idle after done", out_n, n0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule